// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits on a simple I/O bus and turns the two-port legacy configuration access scheme into per-device configuration requests. One I/O port holds a 32-bit configuration address latch. A four-byte data window carries the data. The latch names a target by bus, device and function, and gives a register offset. An access to the window is turned into a dword-aligned request for one of a parameterized set of device register files. The request carries a one-hot device select, a byte-lane enable mask and lane-aligned write data.

The I/O bus presents a port number, a direction, a 32-bit write word and an access size in bytes. The decoder claims only the latch port and the four window ports. For window reads it picks the addressed device's dword and shifts it down to the starting lane. When the latch is disabled or names no device, a read returns all ones and a write is dropped. The only state is the address latch. All decoding is combinational within the access cycle, and a latch write takes effect at the next clock edge.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write to port 0x0CF8 loads the whole 32-bit write word into the address latch at the next clock edge. No other access changes the latch.
- R2: A read of port 0x0CF8 returns the latch with bits 30:24 and bits 1:0 cleared.
- R3: Ports 0x0CF8 and 0x0CFC..0x0CFF are claimed (`io_claim` high). Any other port is unclaimed, reads 0 and raises no request.
- R4: For a window access, the byte enable equals the low `io_size` lanes set (size 1, 2 or 4), shifted left by port bits 1:0. Lanes above lane 3 are dropped.
- R5: Window write data is shifted left by 8 × port bits 1:0 and truncated to 32 bits.
- R6: A request is raised only when latch bit 31 is set and latch bits 23:16 (bus), 15:11 (device) and 10:8 (function) equal one device's identifier. `cfg_sel` is then one-hot on that device.
- R7: The register offset sent is latch bits 7:2 with bits 1:0 forced to zero.
- R8: A window read with latch bit 31 clear, or with no matching device, returns 0xFFFFFFFF. A window write under the same conditions raises no request.
- R9: A window read returns the selected device's dword shifted right by 8 × port bits 1:0, with zeros shifted in. It is not narrowed to the access size.
- R10: After reset the latch holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port number |
| io_size | input | 3 | Access size in bytes (1, 2 or 4) |
| io_wdata | input | 32 | I/O write word, lane 0 aligned |
| io_claim | output | 1 | Port belongs to this decoder |
| io_rdata | output | 32 | Read result, lane 0 aligned |
| cfg_req | output | 1 | Configuration request to a device |
| cfg_write | output | 1 | Request is a write |
| cfg_sel | output | N_DEV | One-hot device select |
| cfg_offset | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32·N_DEV | Per-device read dwords, device i at bits 32i+31:32i |

## Verification
The assertions assume that `io_size` is always 1, 2 or 4 on a valid access. They also assume that the device identifiers given at elaboration are distinct. Under those assumptions a request never has an empty lane mask and never selects two devices. The stimulus uses only those three sizes and the default set of distinct identifiers. It reaches misses through a disabled latch and through an identifier that matches no device. It also covers unaligned window ports and lanes that spill past lane 3.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int DW    = 32;
   localparam int LANES = DW / 8;
   localparam int OFF_W = $clog2(LANES);

   // lanes [size-1:0] set, moved up by the starting lane, upper spill dropped
   function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size,
                                                  input logic [OFF_W-1:0] off);
      logic [2*LANES-1:0] wide;
      wide = (2*LANES)'((9'd1 << size) - 9'd1);
      wide = wide << off;
      return wide[LANES-1:0];
   endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
   parameter int          AW        = 32,
   parameter logic [31:0] HIDE_BITS = 32'h7F00_0003
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] din,
   output logic [AW-1:0] q,
   output logic [AW-1:0] rb
);
   if (AW != 32) begin : g_bad_aw
      $error("cfg_addr_latch: AW must be 32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= din;
   end

   assign rb = q & ~HIDE_BITS[AW-1:0];

   // R1
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(din));
   // R1
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/cfg_dev_match.sv
module cfg_dev_match #(
   parameter int                   N_DEV    = 3,
   parameter int                   ID_W     = 16,
   parameter logic [N_DEV*ID_W-1:0] DEV_IDS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [ID_W-1:0]  id,
   output logic [N_DEV-1:0] sel,
   output logic             hit
);
   if (N_DEV < 1) begin : g_bad_n
      $error("cfg_dev_match: N_DEV must be at least 1");
   end

   for (genvar a = 0; a < N_DEV; a++) begin : g_uniq
      for (genvar b = a + 1; b < N_DEV; b++) begin : g_pair
         if (DEV_IDS[a*ID_W +: ID_W] == DEV_IDS[b*ID_W +: ID_W]) begin : g_dup
            $error("cfg_dev_match: duplicate device identifier");
         end
      end
   end

   for (genvar i = 0; i < N_DEV; i++) begin : g_cmp
      assign sel[i] = enable && (id == DEV_IDS[i*ID_W +: ID_W]);
   end

   assign hit = |sel;

   // R6
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R6
   sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> enable);
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
   import cfgp_pkg::*;
(
   input  logic [OFF_W-1:0] off,
   input  logic [2:0]       size,
   input  logic [DW-1:0]    wdata_in,
   input  logic [DW-1:0]    rdata_in,
   output logic [LANES-1:0] be,
   output logic [DW-1:0]    wdata_out,
   output logic [DW-1:0]    rdata_out
);
   logic [OFF_W+2:0] bit_sh;

   assign bit_sh    = {off, 3'b000};
   assign be        = lane_mask(size, off);
   assign wdata_out = wdata_in << bit_sh;
   assign rdata_out = rdata_in >> bit_sh;
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
   import cfgp_pkg::*;
#(
   parameter int                  N_DEV     = 3,
   parameter logic [15:0]         ADDR_PORT = 16'h0CF8,
   parameter logic [15:0]         DATA_PORT = 16'h0CFC,
   parameter logic [N_DEV*16-1:0] DEV_IDS   = {16'h0110, 16'h0008, 16'h0000}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_valid,
   input  logic               io_write,
   input  logic [15:0]        io_port,
   input  logic [2:0]         io_size,
   input  logic [31:0]        io_wdata,
   output logic               io_claim,
   output logic [31:0]        io_rdata,
   output logic               cfg_req,
   output logic               cfg_write,
   output logic [N_DEV-1:0]   cfg_sel,
   output logic [7:0]         cfg_offset,
   output logic [3:0]         cfg_be,
   output logic [31:0]        cfg_wdata,
   input  logic [N_DEV*32-1:0] cfg_rdata
);
   localparam int WIN_LSB = OFF_W;

   if (DATA_PORT[WIN_LSB-1:0] != '0) begin : g_bad_win
      $error("cfg_port_decoder: DATA_PORT must be window aligned");
   end
   if (DW != 32) begin : g_bad_dw
      $error("cfg_port_decoder: data width must be 32");
   end

   logic            at_addr, at_data;
   logic [31:0]     latch_q, latch_rb;
   logic            dev_hit;
   logic [N_DEV-1:0] dev_sel;
   logic [31:0]     dev_dword, rd_shifted;

   assign at_addr  = io_valid && (io_port == ADDR_PORT);
   assign at_data  = io_valid && (io_port[15:WIN_LSB] == DATA_PORT[15:WIN_LSB]);
   assign io_claim = at_addr || at_data;

   cfg_addr_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (at_addr && io_write),
      .din   (io_wdata),
      .q     (latch_q),
      .rb    (latch_rb)
   );

   cfg_dev_match #(.N_DEV(N_DEV), .ID_W(16), .DEV_IDS(DEV_IDS)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (latch_q[31]),
      .id     (latch_q[23:8]),
      .sel    (dev_sel),
      .hit    (dev_hit)
   );

   // AND-OR read mux over the one-hot select
   always_comb begin
      dev_dword = '0;
      for (int i = 0; i < N_DEV; i++)
         dev_dword |= cfg_rdata[i*32 +: 32] & {32{dev_sel[i]}};
   end

   cfg_lane_align u_align (
      .off       (io_port[WIN_LSB-1:0]),
      .size      (io_size),
      .wdata_in  (io_wdata),
      .rdata_in  (dev_dword),
      .be        (cfg_be),
      .wdata_out (cfg_wdata),
      .rdata_out (rd_shifted)
   );

   assign cfg_req    = at_data && dev_hit;
   assign cfg_write  = io_write;
   assign cfg_sel    = cfg_req ? dev_sel : '0;
   assign cfg_offset = {latch_q[7:2], 2'b00};

   always_comb begin
      io_rdata = '0;
      if (io_valid && !io_write) begin
         if (at_addr)      io_rdata = latch_rb;
         else if (at_data) io_rdata = dev_hit ? rd_shifted : '1;
      end
   end

   // R3
   req_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> io_claim);
   // R6
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> latch_q[31] && $onehot(cfg_sel));
   // R4
   be_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> cfg_be != 4'b0000);
   // R8
   miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_data && !io_write && !cfg_req) |-> io_rdata == 32'hFFFF_FFFF);
   // R2
   addr_rb_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_addr && !io_write) |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0));
   // R3
   unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_claim |-> (io_rdata == 32'd0 && !cfg_req));
endmodule

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
   localparam int N_DEV = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               io_valid = 1'b0, io_write = 1'b0;
   logic [15:0]        io_port = '0;
   logic [2:0]         io_size = 3'd4;
   logic [31:0]        io_wdata = '0;
   logic               io_claim, cfg_req, cfg_write;
   logic [31:0]        io_rdata, cfg_wdata;
   logic [N_DEV-1:0]   cfg_sel;
   logic [7:0]         cfg_offset;
   logic [3:0]         cfg_be;
   logic [N_DEV*32-1:0] cfg_rdata;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cfg_port_decoder uut (.*);

   // bench model of register files: device i returns D<i>00<off>C3
   always_comb
      for (int i = 0; i < N_DEV; i++)
         cfg_rdata[i*32 +: 32] = {4'hD, 4'(i), 8'h00, cfg_offset, 8'hC3};

   typedef struct packed {
      logic        wr;
      logic [15:0] port;
      logic [2:0]  size;
      logic [31:0] wdata;
      logic        claim;
      logic        req;
      logic [2:0]  sel;
      logic [3:0]  be;
      logic [7:0]  off;
      logic [31:0] cwd;
      logic [31:0] rd;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VT [NV] = '{
      // R1: enable, bus0 dev1 fn0, reg 0x10
      '{1'b1,16'h0CF8,3'd4,32'h8000_0810,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd1},
      // R2
      '{1'b0,16'h0CF8,3'd4,32'h0,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h8000_0810,8'd2},
      // R6 R7 R9 full dword
      '{1'b0,16'h0CFC,3'd4,32'h0,1'b1,1'b1,3'b010,4'hF,8'h10,32'h0,32'hD100_10C3,8'd9},
      // R4 R9 word at lane 2
      '{1'b0,16'h0CFE,3'd2,32'h0,1'b1,1'b1,3'b010,4'hC,8'h10,32'h0,32'h0000_D100,8'd4},
      // R4 R9 byte at lane 3
      '{1'b0,16'h0CFF,3'd1,32'h0,1'b1,1'b1,3'b010,4'h8,8'h10,32'h0,32'h0000_00D1,8'd9},
      // R5 byte write lane 1
      '{1'b1,16'h0CFD,3'd1,32'h0000_00AB,1'b1,1'b1,3'b010,4'h2,8'h10,32'h0000_AB00,32'h0,8'd5},
      // R4 R5 dword at lane 2 spills
      '{1'b1,16'h0CFE,3'd4,32'h1122_3344,1'b1,1'b1,3'b010,4'hC,8'h10,32'h3344_0000,32'h0,8'd5},
      // R1: hidden bits set, id 000F matches nothing
      '{1'b1,16'h0CF8,3'd4,32'hFF00_0F13,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd1},
      // R2
      '{1'b0,16'h0CF8,3'd4,32'h0,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h8000_0F10,8'd2},
      // R8 miss read
      '{1'b0,16'h0CFC,3'd4,32'h0,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'hFFFF_FFFF,8'd8},
      // R8 miss write dropped
      '{1'b1,16'h0CFC,3'd4,32'h5555_5555,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd8},
      // R6 enable clear, id 0000 (would be device 0)
      '{1'b1,16'h0CF8,3'd4,32'h0000_0010,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd6},
      // R8 disabled read
      '{1'b0,16'h0CFD,3'd1,32'h0,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'hFFFF_FFFF,8'd8},
      // R6 bus1 dev2 fn0 -> device 2, reg 0x24
      '{1'b1,16'h0CF8,3'd4,32'h8001_1024,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd6},
      '{1'b0,16'h0CFC,3'd4,32'h0,1'b1,1'b1,3'b100,4'hF,8'h24,32'h0,32'hD200_24C3,8'd6},
      // R3 foreign port read
      '{1'b0,16'h0080,3'd4,32'h0,1'b0,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd3},
      // R3 R1 foreign write next to latch, latch must be kept
      '{1'b1,16'h0CF9,3'd1,32'h0000_0000,1'b0,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd3},
      '{1'b0,16'h0CF8,3'd4,32'h0,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h8001_1024,8'd1},
      // R7: low latch bits set, device 0 reg 0
      '{1'b1,16'h0CF8,3'd4,32'h8000_0003,1'b1,1'b0,3'b000,4'h0,8'h00,32'h0,32'h0,8'd7}
   };

   task automatic chk(input string what, input int rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [15:0] port, input logic [2:0] size,
                        input logic [31:0] wd);
      @(negedge clk);
      io_valid = 1'b1; io_write = wr; io_port = port; io_size = size; io_wdata = wd;
      #2;
   endtask

   task automatic idle();
      @(negedge clk);
      io_valid = 1'b0; io_write = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state of latch, seen through readback
      drive(1'b0, 16'h0CF8, 3'd4, 32'h0);
      chk("latch after reset", 10, io_rdata, 32'h0);
      chk("no request at reset", 10, {31'd0, cfg_req}, 32'd0);
      idle();

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].wr, VT[i].port, VT[i].size, VT[i].wdata);
         chk($sformatf("vec %0d claim", i), VT[i].rq, {31'd0, io_claim}, {31'd0, VT[i].claim});
         chk($sformatf("vec %0d req", i), VT[i].rq, {31'd0, cfg_req}, {31'd0, VT[i].req});
         if (VT[i].req) begin
            chk($sformatf("vec %0d sel", i), VT[i].rq, {29'd0, cfg_sel}, {29'd0, VT[i].sel});
            chk($sformatf("vec %0d be", i), VT[i].rq, {28'd0, cfg_be}, {28'd0, VT[i].be});
            chk($sformatf("vec %0d offset", i), VT[i].rq, {24'd0, cfg_offset}, {24'd0, VT[i].off});
            chk($sformatf("vec %0d dir", i), VT[i].rq, {31'd0, cfg_write}, {31'd0, VT[i].wr});
            if (VT[i].wr)
               chk($sformatf("vec %0d wdata", i), VT[i].rq, cfg_wdata, VT[i].cwd);
         end
         if (!VT[i].wr)
            chk($sformatf("vec %0d rdata", i), VT[i].rq, io_rdata, VT[i].rd);
         idle();
      end

      // R7 R2: latch 80000003 reads back with low bits hidden; offset is 0
      drive(1'b0, 16'h0CF8, 3'd4, 32'h0);
      chk("R2 low bits hidden", 2, io_rdata, 32'h8000_0000);
      idle();
      drive(1'b0, 16'h0CFD, 3'd2, 32'h0);
      chk("R7 offset aligned", 7, {24'd0, cfg_offset}, 32'h0);
      chk("R9 dev0 lane1 read", 9, io_rdata, 32'h00D0_0000);
      chk("R4 be word lane1", 4, {28'd0, cfg_be}, 32'h6);
      chk("R6 select dev0", 6, {29'd0, cfg_sel}, 32'h1);
      idle();

      // R10 reset clears a loaded latch
      drive(1'b1, 16'h0CF8, 3'd4, 32'h8000_0800);
      idle();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 16'h0CF8, 3'd4, 32'h0);
      chk("R10 latch cleared by reset", 10, io_rdata, 32'h0);
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule